// File: doc/BRIEF.md
# Windowed Wide-State Readout Port

This block gives software a narrow view into a set of wide internal state records. Each record is 448 bits, and up to sixteen of them arrive on one flattened input vector. A 4-bit select register picks a record. A 32-bit read window then returns that record one slice per read. An internal word pointer steps through the 14 slices of the record. It starts at the least significant word, moves toward the most significant word, and wraps to zero after the last slice, so software can read the same record again without rewriting anything.

Writing the select register puts the pointer back to the first word. Only the first `rec_count` records are populated, and a selection at or beyond that count reads as zero. Two qualifiers must both be high before the window returns data: the readout enable from the control register and the enable from fuses. When either is low, the window reads as zero and a read does not move the pointer.

Top module: `state_window_reader`

## Requirements
- R1: After reset the select register reads 0 and the word pointer is at word 0.
- R2: `sel_rdata` always shows the value most recently written through `sel_wr`/`sel_wdata`.
- R3: With reads enabled and the selection populated, `win_rdata` during a read strobe equals bits [32k+31:32k] of the selected record, where k is the word pointer. Record r occupies bits [448r+447:448r] of `records`.
- R4: Each enabled read strobe advances the pointer by one. After the 14th read (k = 13) it returns to 0, so the 15th read shows word 0 again.
- R5: A write to the select register resets the pointer to 0. If a read strobe falls in the same cycle, the write wins and the pointer ends at 0.
- R6: When the selection is greater than or equal to `rec_count`, `win_rdata` is zero. An enabled read still advances the pointer.
- R7: Unless both `state_rd_en` and `fuse_rd_en` are 1, `win_rdata` is zero and a read strobe leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Select register write strobe |
| sel_wdata | input | 4 | Select register write data |
| sel_rdata | output | 4 | Select register readback |
| win_rd | input | 1 | Window read strobe |
| records | input | 7168 | Flattened state records, record r at bits [448r+447:448r] |
| rec_count | input | 5 | Number of populated records |
| state_rd_en | input | 1 | Readout enable from the control register |
| fuse_rd_en | input | 1 | Readout enable from fuses |
| win_rdata | output | 32 | Window read data |

## Verification
Every record holds words whose value encodes both the record number and the word index. A full sweep of all sixteen selections, reading one word past the end of each, therefore shows any error in slice ordering, in record selection or in the wrap point.

The sweep is repeated with a smaller populated count, which separates the zero returned for an unpopulated selection from real data. Reads with each enable dropped show whether a disabled read leaks data or moves the pointer. A select write placed mid-record, and another placed in the same cycle as a read, show that the pointer reset takes priority.

// File: rtl/winrd_pkg.sv
package winrd_pkg;
  // Next word index with wrap after the last word.
  function automatic int unsigned ptr_step(int unsigned ptr, int unsigned words);
    return (ptr + 1 >= words) ? 0 : ptr + 1;
  endfunction

  // Bit offset of a slice inside the flattened record vector.
  function automatic int unsigned slice_base(int unsigned sel, int unsigned ptr,
                                             int unsigned rec_w, int unsigned word_w);
    return sel * rec_w + ptr * word_w;
  endfunction
endpackage

// File: rtl/winrd_sel_reg.sv
module winrd_sel_reg #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sel <= '0;
    else if (wr) sel <= wdata;
  end

  // R2: a write is visible on the next cycle
  assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> sel == $past(wdata));
  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(sel));
endmodule

// File: rtl/winrd_word_ptr.sv
module winrd_word_ptr #(
  parameter int WORDS = 14,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [PTR_W-1:0] ptr,
  output logic             wrap_evt
);
  import winrd_pkg::*;

  assign wrap_evt = step && !restart && (int'(ptr) == WORDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (restart) ptr <= '0;
    else if (step)    ptr <= PTR_W'(ptr_step(int'(ptr), WORDS));
  end

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < WORDS);
  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ptr == '0);
  assert_ptr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ptr == '0);
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(ptr));
endmodule

// File: rtl/winrd_slice_mux.sv
module winrd_slice_mux #(
  parameter int NUM_REC = 16,
  parameter int REC_W   = 448,
  parameter int WORD_W  = 32,
  parameter int SEL_W   = 4,
  parameter int PTR_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic [NUM_REC*REC_W-1:0] records,
  input  logic [SEL_W-1:0]         sel,
  input  logic [PTR_W-1:0]         ptr,
  input  logic [CNT_W-1:0]         count,
  input  logic                     en,
  output logic                     populated,
  output logic [WORD_W-1:0]        rdata
);
  import winrd_pkg::*;

  int unsigned base;

  assign populated = int'(sel) < int'(count);

  always_comb begin
    base  = slice_base(int'(sel), int'(ptr), REC_W, WORD_W);
    rdata = '0;
    if (en && populated) rdata = records[base +: WORD_W];
  end
endmodule

// File: rtl/state_window_reader.sv
module state_window_reader #(
  parameter int NUM_REC = 16,
  parameter int REC_W   = 448,
  parameter int WORD_W  = 32,
  localparam int WORDS  = REC_W / WORD_W,
  localparam int SEL_W  = $clog2(NUM_REC),
  localparam int PTR_W  = $clog2(WORDS),
  localparam int CNT_W  = $clog2(NUM_REC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_wr,
  input  logic [SEL_W-1:0]         sel_wdata,
  output logic [SEL_W-1:0]         sel_rdata,
  input  logic                     win_rd,
  input  logic [NUM_REC*REC_W-1:0] records,
  input  logic [CNT_W-1:0]         rec_count,
  input  logic                     state_rd_en,
  input  logic                     fuse_rd_en,
  output logic [WORD_W-1:0]        win_rdata
);
  logic             rd_allowed;
  logic             rd_step;
  logic             populated;
  logic             wrap_evt;
  logic [PTR_W-1:0] ptr;

  assign rd_allowed = state_rd_en && fuse_rd_en;
  assign rd_step    = win_rd && rd_allowed;

  winrd_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_wdata), .sel(sel_rdata)
  );

  winrd_word_ptr #(.WORDS(WORDS), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .restart(sel_wr), .step(rd_step),
    .ptr(ptr), .wrap_evt(wrap_evt)
  );

  winrd_slice_mux #(
    .NUM_REC(NUM_REC), .REC_W(REC_W), .WORD_W(WORD_W),
    .SEL_W(SEL_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_mux (
    .records(records), .sel(sel_rdata), .ptr(ptr), .count(rec_count),
    .en(rd_allowed), .populated(populated), .rdata(win_rdata)
  );

  assert_zero_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_allowed |-> win_rdata == '0);
  assert_zero_unpopulated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !populated |-> win_rdata == '0);
  assert_wrap_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> rd_step);
endmodule

// File: tb/state_window_reader_bench.sv
module state_window_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREC  = 16;
  localparam int RECW  = 448;
  localparam int NWORD = 14;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              sel_wr = 0;
  logic [3:0]        sel_wdata = 0;
  logic [3:0]        sel_rdata;
  logic              win_rd = 0;
  logic [NREC*RECW-1:0] records;
  logic [4:0]        rec_count = 5'd16;
  logic              state_rd_en = 1;
  logic              fuse_rd_en = 1;
  logic [31:0]       win_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  state_window_reader u_state_window_reader (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .sel_rdata(sel_rdata), .win_rd(win_rd), .records(records),
    .rec_count(rec_count), .state_rd_en(state_rd_en), .fuse_rd_en(fuse_rd_en),
    .win_rdata(win_rdata)
  );

  function automatic logic [31:0] pattern(int r, int w);
    return {8'(r + 8'h40), 8'(w + 8'h10), 16'h5A00 ^ 16'(r * 37 + w * 11)};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // Caller is at a falling edge; returns at the next falling edge.
  task automatic read_word(output logic [31:0] d);
    win_rd = 1;
    #1 d = win_rdata;
    @(negedge clk);
    win_rd = 0;
  endtask

  task automatic write_sel(int s);
    sel_wr = 1;
    sel_wdata = 4'(s);
    @(negedge clk);
    sel_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int r = 0; r < NREC; r++)
      for (int w = 0; w < NWORD; w++)
        records[r*RECW + w*32 +: 32] = pattern(r, w);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 sel", {28'd0, sel_rdata}, 32'd0);
    read_word(d);
    check("R1 ptr", d, pattern(0, 0));
    write_sel(0);

    // R3 R4 R2: every record, every word, plus one read past the end
    for (int r = 0; r < NREC; r++) begin
      write_sel(r);
      check("R2", {28'd0, sel_rdata}, 32'(r));
      for (int w = 0; w < NWORD; w++) begin
        read_word(d);
        check("R3", d, pattern(r, w));
      end
      read_word(d);
      check("R4 wrap", d, pattern(r, 0));
    end

    // R5: select write mid-record restarts at word 0
    write_sel(7);
    for (int w = 0; w < 5; w++) read_word(d);
    write_sel(7);
    read_word(d);
    check("R5 restart", d, pattern(7, 0));
    // R5: write in the same cycle as a read wins
    read_word(d);
    sel_wr = 1; sel_wdata = 4'd9; win_rd = 1;
    @(negedge clk);
    sel_wr = 0; win_rd = 0;
    read_word(d);
    check("R5 collide", d, pattern(9, 0));

    // R6: populated count of 5
    rec_count = 5'd5;
    for (int r = 0; r < NREC; r++) begin
      write_sel(r);
      for (int w = 0; w < 3; w++) begin
        read_word(d);
        check("R6", d, (r < 5) ? pattern(r, w) : 32'd0);
      end
    end
    // R6: unpopulated reads still advance the pointer
    write_sel(6);
    for (int w = 0; w < 4; w++) read_word(d);
    rec_count = 5'd16;
    read_word(d);
    check("R6 advance", d, pattern(6, 4));
    rec_count = 5'd16;

    // R7: each qualifier low gives zero and no advance
    write_sel(3);
    read_word(d);
    state_rd_en = 0;
    read_word(d);
    check("R7 state off", d, 32'd0);
    read_word(d);
    state_rd_en = 1; fuse_rd_en = 0;
    read_word(d);
    check("R7 fuse off", d, 32'd0);
    fuse_rd_en = 1;
    read_word(d);
    check("R7 no advance", d, pattern(3, 1));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule